// File: doc/BRIEF.md
# Fractional Divider Clock Mux

This block sits between a set of clock-enable sources and one consumer. Each source is a single-cycle tick on the system clock that marks one edge of a slower clock. A source-select field picks one of up to sixteen ticks. An enable bit gates that tick, and a fractional divider thins the selected tick stream before it leaves as one output tick. Index 0 is tied to ground inside the block. Index 1 carries the main oscillator, and indices 2 and 3 carry two test clocks. Any higher index is wired to whatever the instance needs.

The divider word places the integer part of the divisor at bit 12 upward. The fractional part takes the `FRAC_W` bits just below bit 12. The concatenated value D sets the output rate to the source rate times 2^FRAC_W / D. The divider works as a phase accumulator. Each selected tick adds 2^FRAC_W, and each output tick removes D. A divisor of zero stops the output. An instance with no integer bits and no fraction bits is a plain registered gate. A busy flag follows the enable bit.

Top module: `fdm_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_tick` and `busy` are 0, and the accumulator holds zero.
- R2: `ctl_src` chooses which bit of `src_tick` feeds the divider, and ticks on all other bits have no effect. Index 0 never produces a tick, and an index at or above `NSRC` never produces a tick.
- R3: While `ctl_en` is 0, `out_tick` stays 0 on the following cycle and the accumulator is cleared.
- R4: `busy` equals the value `ctl_en` had on the previous clock cycle.
- R5: The divisor D is `div_word[12+INT_W-1 : 12-FRAC_W]`. Bits of `div_word` below bit `12-FRAC_W` have no effect.
- R6: Starting from a cleared accumulator, with D greater than 2^FRAC_W, the k-th selected tick produces an output tick exactly when floor(k*2^FRAC_W/D) increases. After N ticks, the output has therefore given floor(N*2^FRAC_W/D) ticks. Each output tick appears one cycle after the source tick that caused it.
- R7: With D nonzero and D at most 2^FRAC_W, every counted selected tick produces an output tick one cycle later.
- R8: With D equal to zero, `out_tick` stays 0.
- R9: With `INT_W` and `FRAC_W` both 0, `out_tick` equals the selected, enabled tick of the previous cycle, and `div_word` is ignored.
- R10: In a cycle where `ctl_src` differs from its value in the previous cycle, the accumulator restarts at zero and the tick of that cycle is not counted.
- R11: `out_tick` is 1 only if the selected source ticked, with the block enabled, in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | NSRC | One clock-enable tick per source; bit 0 is ignored (ground) |
| ctl_en | input | 1 | Enable for the output |
| ctl_src | input | SRC_W | Source index |
| div_word | input | 12+INT_W | Divider register value: integer part from bit 12 up, fraction just below |
| out_tick | output | 1 | Divided output tick |
| busy | output | 1 | Enable state as seen by the block |

## Verification
The bench builds two instances. The first has eight sources, three integer bits and two fraction bits. This gives a 5-bit divisor, so the bench sweeps every divisor value from zero to 31 and compares the tick counts with floor(N*4/D). The sweep includes the zero-divisor case and the divisors at or below four, where every tick comes through. Gapped tick streams, junk in the low divider bits, source selection, ground and a source switch in the middle of a phase run on this instance. The second instance has no integer or fraction bits, which brings the bypass variant within reach and lets the bench check it cycle by cycle.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
   // Bit position where the integer part of the divisor begins.
   localparam int INT_LSB = 12;
   // Largest number of selectable sources.
   localparam int MAX_SRC = 16;
endpackage

// File: rtl/fdm_pick.sv
module fdm_pick #(
   parameter int NSRC  = 16,
   parameter int SRC_W = 4
) (
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SRC_W-1:0] ctl_src,
   output logic             sel_tick
);
   localparam int SPAN = 1 << SRC_W;

   logic [SPAN-1:0] masked;
   logic            unused_ground;

   assign unused_ground = src_tick[0];

   for (genvar i = 0; i < SPAN; i++) begin : g_lane
      if (i == 0 || i >= NSRC) begin : g_gnd
         assign masked[i] = 1'b0;
      end else begin : g_src
         assign masked[i] = src_tick[i];
      end
   end

   assign sel_tick = masked[ctl_src];

   // R2: index zero is ground
   always_comb begin
      a_r2_ground_silent: assert (ctl_src != '0 || !sel_tick);
   end
endmodule

// File: rtl/fdm_phase.sv
module fdm_phase #(
   parameter int INT_W  = 12,
   parameter int FRAC_W = 12,
   parameter int DIV_W  = fdm_pkg::INT_LSB + INT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [DIV_W-1:0] div_word,
   output logic             pulse
);
   localparam int DW = INT_W + FRAC_W;

   logic pulse_q;
   logic unused_div;

   assign unused_div = ^div_word;
   assign pulse      = pulse_q;

   if (DW == 0) begin : g_bypass
      always_ff @(posedge clk) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= tick & ~clr;
      end

      // R9: bypass passes every counted tick
      a_r9_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !clr) |=> pulse_q);
   end else begin : g_acc
      localparam int LSB = fdm_pkg::INT_LSB - FRAC_W;
      localparam logic [DW:0] STEP = (DW+1)'(1) << FRAC_W;

      logic [DW-1:0] dv;
      logic [DW-1:0] acc_q;
      logic [DW:0]   nxt;
      logic [DW:0]   rem;
      logic          reach;
      logic          live;

      assign dv    = div_word[fdm_pkg::INT_LSB+INT_W-1:LSB];
      assign nxt   = {1'b0, acc_q} + STEP;
      assign rem   = nxt - {1'b0, dv};
      assign reach = nxt >= {1'b0, dv};
      assign live  = tick & ~clr & (dv != '0);

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            acc_q <= '0;
         end else if (live) begin
            if (!reach)                 acc_q <= nxt[DW-1:0];
            else if (rem >= {1'b0, dv}) acc_q <= '0;
            else                        acc_q <= rem[DW-1:0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= live & reach;
      end

      // R8: zero divisor never emits
      a_r8_zero_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (dv == '0) |=> !pulse_q);
      // R7: divisor at or below one step passes each tick
      a_r7_fast_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !clr && dv != '0 && {1'b0, dv} <= STEP) |=> pulse_q);
   end
endmodule

// File: rtl/fdm_top.sv
module fdm_top #(
   parameter int NSRC   = 16,
   parameter int INT_W  = 12,
   parameter int FRAC_W = 12,
   parameter int SRC_W  = 4,
   localparam int DIV_W = fdm_pkg::INT_LSB + INT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_tick,
   input  logic             ctl_en,
   input  logic [SRC_W-1:0] ctl_src,
   input  logic [DIV_W-1:0] div_word,
   output logic             out_tick,
   output logic             busy
);
   if (FRAC_W > fdm_pkg::INT_LSB) begin : g_bad_frac
      $error("FRAC_W must not exceed the integer start bit");
   end
   if (NSRC < 2 || NSRC > fdm_pkg::MAX_SRC || NSRC > (1 << SRC_W)) begin : g_bad_nsrc
      $error("NSRC out of range for SRC_W");
   end
   if (INT_W < 0 || INT_W > 20) begin : g_bad_int
      $error("INT_W out of range");
   end

   logic             sel_tick;
   logic [SRC_W-1:0] src_q;
   logic             busy_q;
   logic             seen_q;
   logic             clr;

   fdm_pick #(.NSRC(NSRC), .SRC_W(SRC_W)) u_pick (
      .src_tick (src_tick),
      .ctl_src  (ctl_src),
      .sel_tick (sel_tick)
   );

   // Clear on disable, and on any change of the source index.
   assign clr = ~ctl_en | (ctl_src != src_q);

   fdm_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sel_tick),
      .clr      (clr),
      .div_word (div_word),
      .pulse    (out_tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         busy_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         src_q  <= ctl_src;
         busy_q <= ctl_en;
         seen_q <= 1'b1;
      end
   end

   assign busy = busy_q;

   // R4: busy lags enable by one cycle
   a_r4_busy_tracks: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
      busy == $past(ctl_en));
   // R3: disabled means quiet next cycle
   a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> !out_tick);
   // R11: every output needs a selected tick one cycle earlier
   a_r11_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
      out_tick |-> $past(sel_tick && ctl_en));
   // R10: a source switch swallows that cycle's tick
   a_r10_switch_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_src != src_q) |=> !out_tick);
endmodule

// File: tb/sim_fdm_top.sv
module sim_fdm_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [7:0]  t0 = '0;
   logic        en0 = 1'b0;
   logic [3:0]  s0 = 4'd1;
   logic [14:0] dw0 = '0;
   logic        o0, b0;

   logic [3:0]  t1 = '0;
   logic        en1 = 1'b0;
   logic [3:0]  s1 = 4'd1;
   logic [11:0] dw1 = 12'hABC;
   logic        o1, b1;

   fdm_top #(.NSRC(8), .INT_W(3), .FRAC_W(2), .SRC_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .src_tick(t0), .ctl_en(en0), .ctl_src(s0),
      .div_word(dw0), .out_tick(o0), .busy(b0));

   fdm_top #(.NSRC(4), .INT_W(0), .FRAC_W(0), .SRC_W(4)) u1 (
      .clk(clk), .rst_n(rst_n), .src_tick(t1), .ctl_en(en1), .ctl_src(s1),
      .div_word(dw1), .out_tick(o1), .busy(b1));

   int cnt0 = 0;
   int n_chk = 0;
   int n_bad = 0;

   always @(negedge clk) if (rst_n && o0) cnt0++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // Clear the accumulator with one disabled cycle, then load a divisor.
   task automatic restart(input int d, input logic [9:0] low);
      @(negedge clk) en0 = 1'b0;
      @(negedge clk) begin en0 = 1'b1; dw0 = {d[4:0], low}; end
   endtask

   // Drive n ticks with gap idle cycles between them; return output count.
   task automatic run(input int n, input int gap, input logic [7:0] mask, output int got);
      int base;
      base = cnt0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk) t0 = mask;
         for (int g = 0; g < gap; g++) @(negedge clk) t0 = '0;
      end
      @(negedge clk) t0 = '0;
      repeat (2) @(negedge clk);
      got = cnt0 - base;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int got, exp;
      logic prev;
      repeat (3) @(negedge clk);
      chk(o0 == 0 && o1 == 0, "R1 out in reset", o0, 0);
      chk(b0 == 0, "R1 busy in reset", b0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(o0 == 0 && b0 == 0, "R1 first cycle", {o0, b0}, 0);

      // R4 busy follows enable
      en0 = 1'b1;
      @(negedge clk);
      chk(b0 == 1, "R4 busy rises", b0, 1);
      en0 = 1'b0;
      @(negedge clk);
      chk(b0 == 0, "R4 busy falls", b0, 0);

      // R6 R7 R8 full divisor sweep, one tick per cycle
      for (int d = 0; d < 32; d++) begin
         restart(d, '0);
         run(40, 0, 8'h02, got);
         exp = (d == 0) ? 0 : ((d <= 4) ? 40 : (160 / d));
         chk(got == exp, d == 0 ? "R8 zero divisor" : (d <= 4 ? "R7 fast divisor" : "R6 rate"), got, exp);
      end

      // R6 gapped tick streams
      restart(10, '0);
      run(30, 2, 8'h02, got);
      chk(got == 12, "R6 gapped D=10", got, 12);
      restart(13, '0);
      run(30, 2, 8'h02, got);
      chk(got == 9, "R6 gapped D=13", got, 9);

      // R6 output timing: one tick at D=4 shows up one cycle later
      restart(4, '0);
      @(negedge clk) t0 = 8'h02;
      @(negedge clk) begin prev = o0; t0 = '0; end
      chk(prev == 1, "R6 one-cycle latency", prev, 1);
      @(negedge clk);
      chk(o0 == 0, "R6 single pulse", o0, 0);

      // R5 low bits ignored
      restart(10, 10'h3FF);
      run(40, 0, 8'h02, got);
      chk(got == 16, "R5 low bits ignored", got, 16);

      // R2 selection
      @(negedge clk) s0 = 4'd2;
      restart(8, '0);
      run(40, 0, 8'h02, got);
      chk(got == 0, "R2 unselected source", got, 0);
      run(40, 0, 8'h04, got);
      chk(got == 20, "R2 selected source 2", got, 20);
      @(negedge clk) s0 = 4'd0;
      restart(4, '0);
      run(20, 0, 8'hFF, got);
      chk(got == 0, "R2 ground source", got, 0);
      @(negedge clk) s0 = 4'd9;
      restart(4, '0);
      run(20, 0, 8'hFF, got);
      chk(got == 0, "R2 index beyond NSRC", got, 0);

      // R3 disabled
      @(negedge clk) s0 = 4'd1;
      restart(4, '0);
      @(negedge clk) en0 = 1'b0;
      run(20, 0, 8'hFF, got);
      chk(got == 0, "R3 disabled quiet", got, 0);
      chk(b0 == 0, "R4 busy while disabled", b0, 0);

      // R10 source switch clears phase: D=12, step 4
      restart(12, '0);
      begin
         int base;
         base = cnt0;
         @(negedge clk) t0 = 8'hFF;
         @(negedge clk);
         @(negedge clk) s0 = 4'd2;
         @(negedge clk);
         @(negedge clk);
         @(negedge clk) t0 = '0;
         repeat (2) @(negedge clk);
         got = cnt0 - base;
      end
      chk(got == 0, "R10 switch resets phase", got, 0);
      @(negedge clk) t0 = 8'hFF;
      @(negedge clk) t0 = '0;
      repeat (2) @(negedge clk);
      got = cnt0 - got;
      chk(cnt0 >= 1, "R10 phase resumes after switch", cnt0, 1);

      // R9 bypass variant, cycle by cycle
      @(negedge clk) en1 = 1'b1;
      prev = 1'b0;
      for (int k = 0; k < 18; k++) begin
         @(negedge clk);
         if (k > 0) chk(o1 == prev, "R9 bypass follows", o1, prev);
         t1 = (k % 3 != 0) ? 4'h2 : 4'h1;
         prev = (k % 3 != 0);
         dw1 = 12'(k * 37);
      end
      @(negedge clk) begin t1 = '0; en1 = 1'b0; end
      chk(o1 == prev, "R9 bypass last", o1, prev);
      @(negedge clk);
      chk(o1 == 0, "R11 no tick no output", o1, 0);

      finish_run();
   end
endmodule